// File: doc/BRIEF.md
# Video Address Bus Source Selector

This block produces the external address bus of a tile-based video processor, as seen by a cartridge mapper that watches the pins. The bus has two possible sources. While rendering is enabled, it carries the address of the most recent rendering fetch. While rendering is off, it carries the CPU-programmed VRAM pointer. The CPU loads that pointer through a two-write address port, and the pointer is advanced by every access through the data port.

The block drives three things: the 14-bit bus value, one-cycle read and write strobes for data-port accesses, and a filtered pulse that marks a rising edge on bus bit 12. Mappers use that pulse to count scanlines. The source switch follows the rendering-enable bit with no extra delay. Toggling rendering can therefore produce a bit-12 edge by itself. Accesses to the palette page (0x3F00–0x3FFF) still place the address on the bus, but they never assert the write strobe.

The CPU port takes at most one operation per cycle. The one exception is a data read and a data write arriving together. All outputs are registered and change on the clock edge that samples the inputs.

Top module: `vbus_source_sel`

## Requirements
- R1: Reset state:
  - `bus_addr` is 0 and `bus_rd`, `bus_wr` and `a12_rise` are 0.
  - The toggle selects the high byte.
  - The low-time counter starts full, so the first rise after reset is reported.
- R2: The address port takes two writes:
  - The first write stores `cpu_wdata[5:0]` as address bits 13:8 and leaves the bus unchanged.
  - The second write forms `{high6, cpu_wdata}`.
  - With rendering off, that value is on `bus_addr` in the cycle after the second write.
- R3: A status read (`status_rd`) resets the toggle, so the next address-port write is taken as the high byte.
- R4: With rendering off, a data-port access drives the current pointer on `bus_addr` for the next cycle and pulses `bus_rd` or `bus_wr` for one cycle.
  - The pointer then advances by 1, or by 32 when `inc_by_row` is 1, wrapping at 14 bits.
  - The bus keeps the old value until the next access.
- R5: When the pointer's bits 13:8 equal 0x3F, a data write still puts the address on the bus, but `bus_wr` stays 0. A data read in that range still pulses `bus_rd`.
- R6: While `render_en` is 1:
  - `bus_addr` takes `fetch_addr` in the cycle after each `fetch_valid` and holds its value otherwise.
  - On the first enabled cycle with no fetch, it shows the last fetch address captured.
  - CPU accesses assert no strobe and do not move the bus, though the pointer still loads and advances.
- R7: In the first cycle with `render_en` at 0 after it was 1, `bus_addr` is loaded with the pointer. An address-port completion or data access in that same cycle takes precedence.
- R8: `a12_rise` is a one-cycle pulse, in the cycle after `bus_addr[12]` first reads 1. It is asserted only if bit 12 read 0 for at least LOW_MIN (default 8) consecutive cycles just before. Edges caused by a source switch are treated the same way.
- R9: A bit-12 rise after fewer than LOW_MIN low cycles produces no pulse.
- R10: A data read and a data write in the same cycle count as one write: `bus_wr` pulses, `bus_rd` stays 0, and the pointer advances once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_port_wr | input | 1 | CPU write to the two-byte address port |
| data_port_wr | input | 1 | CPU write through the data port |
| data_port_rd | input | 1 | CPU read through the data port |
| status_rd | input | 1 | CPU read of the status port (clears the toggle) |
| cpu_wdata | input | 8 | CPU write data |
| inc_by_row | input | 1 | Pointer step select: 0 = +1, 1 = +32 |
| render_en | input | 1 | Rendering enabled |
| fetch_valid | input | 1 | A rendering fetch occurs this cycle |
| fetch_addr | input | 14 | Address of the rendering fetch |
| bus_addr | output | 14 | External video address bus |
| bus_rd | output | 1 | External read strobe |
| bus_wr | output | 1 | External write strobe |
| a12_rise | output | 1 | Filtered rising-edge pulse on bus bit 12 |

## Verification
A change of `render_en` can land in the same cycle as a CPU access that also wants to load the bus. The falling case meets an address-port completion or a data access; the rising case meets a fetch or its absence. The bench provokes these collisions on purpose, toggling rendering at random while address writes and data accesses continue. Each cycle it compares the bus, the strobes and the edge pulse against a reference built from the precedence rules in R6 and R7. Directed cases place bit-12 rises exactly at and one cycle short of the LOW_MIN low window.

// File: rtl/vbus_pkg.sv
package vbus_pkg;
    localparam int ADDR_W   = 14;
    localparam int HI_W     = ADDR_W - 8;
    localparam int ROW_STEP = 32;
    localparam logic [HI_W-1:0] PAL_PAGE = 6'h3F;

    typedef logic [ADDR_W-1:0] vaddr_t;

    typedef struct packed {
        logic       addr_wr;
        logic       data_wr;
        logic       data_rd;
        logic       status_rd;
        logic [7:0] wdata;
    } cpu_op_t;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_NEW_ADDR,
        SRC_VRAM,
        SRC_FETCH,
        SRC_FETCH_LAST
    } bus_src_e;

    function automatic logic in_palette(vaddr_t a);
        return a[ADDR_W-1 -: HI_W] == PAL_PAGE;
    endfunction

    function automatic vaddr_t step_addr(vaddr_t a, logic row);
        return a + (row ? vaddr_t'(ROW_STEP) : vaddr_t'(1));
    endfunction
endpackage

// File: rtl/vbus_addr_port.sv
module vbus_addr_port
    import vbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cpu_op_t op,
    input  logic    inc_by_row,
    output vaddr_t  vram_addr,
    output logic    set_fire,
    output vaddr_t  set_addr
);
    logic [HI_W-1:0] hi_q;
    logic            tog_q;
    vaddr_t          vram_q;

    assign set_fire  = op.addr_wr & tog_q;
    assign set_addr  = {hi_q, op.wdata};
    assign vram_addr = vram_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            tog_q  <= 1'b0;
            vram_q <= '0;
        end else begin
            if (op.addr_wr && !tog_q)
                hi_q <= op.wdata[HI_W-1:0];

            if (op.status_rd)
                tog_q <= 1'b0;
            else if (op.addr_wr)
                tog_q <= ~tog_q;

            if (set_fire)
                vram_q <= set_addr;
            else if (op.data_wr || op.data_rd)
                vram_q <= step_addr(vram_q, inc_by_row);
        end
    end
endmodule

// File: rtl/vbus_src_mux.sv
module vbus_src_mux
    import vbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   render_en,
    input  logic   fetch_valid,
    input  vaddr_t fetch_addr,
    input  logic   acc_wr,
    input  logic   acc_rd,
    input  logic   set_fire,
    input  vaddr_t set_addr,
    input  vaddr_t vram_addr,
    output vaddr_t bus_addr,
    output logic   bus_rd,
    output logic   bus_wr
);
    vaddr_t   bus_q, flast_q, bus_d;
    logic     ren_q, rd_q, wr_q;
    bus_src_e src;

    always_comb begin
        if (render_en) begin
            if (fetch_valid)      src = SRC_FETCH;
            else if (ren_q)       src = SRC_HOLD;
            else                  src = SRC_FETCH_LAST;
        end else begin
            if (set_fire)                src = SRC_NEW_ADDR;
            else if (acc_wr || acc_rd)   src = SRC_VRAM;
            else if (ren_q)              src = SRC_VRAM;
            else                         src = SRC_HOLD;
        end
    end

    always_comb begin
        case (src)
            SRC_NEW_ADDR:   bus_d = set_addr;
            SRC_VRAM:       bus_d = vram_addr;
            SRC_FETCH:      bus_d = fetch_addr;
            SRC_FETCH_LAST: bus_d = flast_q;
            default:        bus_d = bus_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q   <= '0;
            flast_q <= '0;
            ren_q   <= 1'b0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            bus_q <= bus_d;
            ren_q <= render_en;
            if (fetch_valid)
                flast_q <= fetch_addr;
            wr_q <= !render_en && acc_wr && !in_palette(vram_addr);
            rd_q <= !render_en && acc_rd && !acc_wr;
        end
    end

    assign bus_addr = bus_q;
    assign bus_rd   = rd_q;
    assign bus_wr   = wr_q;
endmodule

// File: rtl/vbus_a12_filter.sv
module vbus_a12_filter #(
    parameter int LOW_MIN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic rise
);
    localparam int CW = $clog2(LOW_MIN + 1);
    localparam logic [CW-1:0] FULL = CW'(LOW_MIN);

    logic [CW-1:0] low_q;
    logic          prev_q;
    logic          rise_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q  <= FULL;
            prev_q <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            rise_q <= bit_in && !prev_q && (low_q >= FULL);
            prev_q <= bit_in;
            if (bit_in)
                low_q <= '0;
            else if (low_q < FULL)
                low_q <= low_q + 1'b1;
        end
    end

    assign rise = rise_q;
endmodule

// File: rtl/vbus_source_sel.sv
module vbus_source_sel
    import vbus_pkg::*;
#(
    parameter int LOW_MIN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_port_wr,
    input  logic              data_port_wr,
    input  logic              data_port_rd,
    input  logic              status_rd,
    input  logic [7:0]        cpu_wdata,
    input  logic              inc_by_row,
    input  logic              render_en,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              a12_rise
);
    cpu_op_t op;
    vaddr_t  vram_addr, set_addr;
    logic    set_fire;

    assign op = '{addr_wr: addr_port_wr, data_wr: data_port_wr,
                  data_rd: data_port_rd, status_rd: status_rd,
                  wdata: cpu_wdata};

    vbus_addr_port u_port (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .inc_by_row (inc_by_row),
        .vram_addr  (vram_addr),
        .set_fire   (set_fire),
        .set_addr   (set_addr)
    );

    vbus_src_mux u_mux (
        .clk         (clk),
        .rst         (rst),
        .render_en   (render_en),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .acc_wr      (data_port_wr),
        .acc_rd      (data_port_rd),
        .set_fire    (set_fire),
        .set_addr    (set_addr),
        .vram_addr   (vram_addr),
        .bus_addr    (bus_addr),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr)
    );

    vbus_a12_filter #(.LOW_MIN(LOW_MIN)) u_filt (
        .clk    (clk),
        .rst    (rst),
        .bit_in (bus_addr[12]),
        .rise   (a12_rise)
    );
endmodule

// File: rtl/vbus_sel_chk.sv
module vbus_sel_chk #(
    parameter int LOW_MIN = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        render_en,
    input logic        fetch_valid,
    input logic [13:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        a12_rise
);
    int chk_low;

    always_ff @(posedge clk) begin
        if (rst)
            chk_low <= LOW_MIN;
        else if (bus_addr[12])
            chk_low <= 0;
        else if (chk_low < LOW_MIN)
            chk_low <= chk_low + 1;
    end

    // R5: write strobe never appears with a palette-page address
    a_r5_no_palette_wr: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> bus_addr[13:8] != 6'h3F);

    // R10: never both strobes
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_rd, bus_wr}));

    // R6: no strobes for accesses made while rendering
    a_r6_no_strobe_render: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |-> !$past(render_en));

    // R6: bus holds when rendering continues without a fetch
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(render_en) && $past(render_en, 2) && !$past(fetch_valid))
        |-> $stable(bus_addr));

    // R8: pulse marks a 0->1 step of bit 12 one cycle earlier
    a_r8_edge_shape: assert property (@(posedge clk) disable iff (rst)
        a12_rise |-> ($past(bus_addr[12]) && !$past(bus_addr[12], 2)));

    // R8: single-cycle pulse
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        a12_rise |=> !a12_rise);

    // R9: pulse only after a long enough low window
    a_r9_low_window: assert property (@(posedge clk) disable iff (rst)
        a12_rise |-> $past(chk_low) >= LOW_MIN);
endmodule

bind vbus_source_sel vbus_sel_chk #(.LOW_MIN(LOW_MIN)) u_chk (.*);

// File: tb/sim_vbus_source_sel.sv
module sim_vbus_source_sel;
    localparam int LMIN = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wa = 0, wd = 0, rdd = 0, rds = 0, row = 0, ren = 0, fv = 0;
    logic [7:0]  din = '0;
    logic [13:0] faddr = '0;
    logic [13:0] bus_addr;
    logic        bus_rd, bus_wr, a12_rise;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    vbus_source_sel #(.LOW_MIN(LMIN)) u0 (
        .clk(clk), .rst(rst), .addr_port_wr(wa), .data_port_wr(wd),
        .data_port_rd(rdd), .status_rd(rds), .cpu_wdata(din),
        .inc_by_row(row), .render_en(ren), .fetch_valid(fv),
        .fetch_addr(faddr), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .a12_rise(a12_rise)
    );

    // reference state
    logic [13:0] m_vram, m_bus, m_flast;
    logic [5:0]  m_hi;
    logic        m_tog, m_renp, m_rd, m_wr, m_p12, m_rise;
    int          m_low;

    task automatic model_reset();
        m_vram = '0; m_bus = '0; m_flast = '0; m_hi = '0; m_tog = 0;
        m_renp = 0; m_rd = 0; m_wr = 0; m_p12 = 0; m_rise = 0; m_low = LMIN;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wa_i, wd_i, rd_i, rs_i, input logic [7:0] d,
                        input logic row_i, ren_i, fv_i, input logic [13:0] fa);
        logic [13:0] n_vram, n_bus, n_flast, newa;
        logic [5:0]  n_hi;
        logic        n_tog, n_rd, n_wr, n_rise, wr2, acc;
        int          n_low;
        wa = wa_i; wd = wd_i; rdd = rd_i; rds = rs_i; din = d;
        row = row_i; ren = ren_i; fv = fv_i; faddr = fa;
        n_rise = m_bus[12] && !m_p12 && (m_low >= LMIN);
        n_low  = m_bus[12] ? 0 : ((m_low < LMIN) ? m_low + 1 : LMIN);
        wr2  = wa_i && m_tog;
        newa = {m_hi, d};
        acc  = wd_i || rd_i;
        n_hi  = (wa_i && !m_tog) ? d[5:0] : m_hi;
        n_tog = rs_i ? 1'b0 : (wa_i ? !m_tog : m_tog);
        n_vram = wr2 ? newa : (acc ? m_vram + (row_i ? 14'd32 : 14'd1) : m_vram);
        n_flast = fv_i ? fa : m_flast;
        if (ren_i) begin
            n_bus = fv_i ? fa : (m_renp ? m_bus : m_flast);
            n_rd = 0; n_wr = 0;
        end else begin
            n_bus = wr2 ? newa : (acc ? m_vram : (m_renp ? m_vram : m_bus));
            n_wr = wd_i && (m_vram[13:8] != 6'h3F);
            n_rd = rd_i && !wd_i;
        end
        @(posedge clk);
        @(negedge clk);
        m_p12 = m_bus[12]; m_low = n_low; m_rise = n_rise;
        m_vram = n_vram; m_bus = n_bus; m_flast = n_flast; m_hi = n_hi;
        m_tog = n_tog; m_renp = ren_i; m_rd = n_rd; m_wr = n_wr;
        chk("R2 R4 R6 R7 bus_addr", 32'(bus_addr), 32'(m_bus));
        chk("R4 R10 bus_rd", 32'(bus_rd), 32'(m_rd));
        chk("R5 R10 bus_wr", 32'(bus_wr), 32'(m_wr));
        chk("R8 R9 a12_rise", 32'(a12_rise), 32'(m_rise));
    endtask

    task automatic idle(input logic ren_i);
        step(0, 0, 0, 0, 8'h00, 0, ren_i, 0, 14'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 bus_addr", 32'(bus_addr), 32'h0);
        chk("R1 bus_rd", 32'(bus_rd), 32'h0);
        chk("R1 bus_wr", 32'(bus_wr), 32'h0);
        chk("R1 a12_rise", 32'(a12_rise), 32'h0);

        // R2 two-write load into the palette page
        step(1, 0, 0, 0, 8'hFF, 0, 0, 0, 14'h0);
        chk("R2 first write leaves bus", 32'(bus_addr), 32'h0);
        step(1, 0, 0, 0, 8'h10, 0, 0, 0, 14'h0);
        chk("R2 second write", 32'(bus_addr), 32'h3F10);
        idle(0);
        chk("R1 R8 rise with full counter", 32'(a12_rise), 32'h1);
        // R5 palette write: address shown, strobe blocked
        step(0, 1, 0, 0, 8'h55, 0, 0, 0, 14'h0);
        chk("R5 palette addr", 32'(bus_addr), 32'h3F10);
        chk("R5 palette wr", 32'(bus_wr), 32'h0);
        step(0, 0, 1, 0, 8'h00, 1, 0, 0, 14'h0);
        chk("R4 R5 read strobe", 32'(bus_rd), 32'h1);
        chk("R4 incremented by 1", 32'(bus_addr), 32'h3F11);
        step(0, 0, 1, 0, 8'h00, 0, 0, 0, 14'h0);
        chk("R4 incremented by 32", 32'(bus_addr), 32'h3F31);

        // R3 status read resets toggle
        step(1, 0, 0, 0, 8'h07, 0, 0, 0, 14'h0);
        step(0, 0, 0, 1, 8'h00, 0, 0, 0, 14'h0);
        step(1, 0, 0, 0, 8'h20, 0, 0, 0, 14'h0);
        step(1, 0, 0, 0, 8'h00, 0, 0, 0, 14'h0);
        chk("R3 toggle cleared", 32'(bus_addr), 32'h2000);

        // R10 simultaneous read and write
        step(0, 1, 1, 0, 8'h00, 0, 0, 0, 14'h0);
        chk("R10 wr wins", 32'(bus_wr), 32'h1);
        chk("R10 no rd", 32'(bus_rd), 32'h0);

        // R6 rendering source
        step(0, 0, 0, 0, 8'h00, 0, 1, 1, 14'h0AAA);
        chk("R6 fetch on bus", 32'(bus_addr), 32'h0AAA);
        idle(1);
        chk("R6 hold", 32'(bus_addr), 32'h0AAA);
        step(0, 1, 0, 0, 8'h00, 0, 1, 0, 14'h0);
        chk("R6 no strobe", 32'(bus_wr), 32'h0);
        chk("R6 bus kept", 32'(bus_addr), 32'h0AAA);
        // R7 switch back
        idle(0);
        chk("R7 pointer on bus", 32'(bus_addr), 32'h2002);

        // R8 rise produced by disabling rendering
        step(0, 0, 0, 0, 8'h00, 0, 1, 1, 14'h0000);
        for (int i = 0; i < 9; i++) idle(1);
        step(1, 0, 0, 0, 8'h10, 0, 1, 0, 14'h0);
        step(1, 0, 0, 0, 8'h00, 0, 1, 0, 14'h0);
        chk("R6 load while rendering", 32'(bus_addr), 32'h0000);
        idle(0);
        chk("R7 switch", 32'(bus_addr), 32'h1000);
        idle(0);
        chk("R8 switch edge", 32'(a12_rise), 32'h1);

        // R9 seven low cycles: blocked; R8 eight low cycles: passed
        for (int i = 0; i < LMIN - 1; i++)
            step(0, 0, 0, 0, 8'h00, 0, 1, 1, 14'h0000);
        step(0, 0, 0, 0, 8'h00, 0, 1, 1, 14'h1000);
        idle(1);
        chk("R9 short low", 32'(a12_rise), 32'h0);
        for (int i = 0; i < LMIN; i++)
            step(0, 0, 0, 0, 8'h00, 0, 1, 1, 14'h0000);
        step(0, 0, 0, 0, 8'h00, 0, 1, 1, 14'h1000);
        idle(1);
        chk("R8 exact window", 32'(a12_rise), 32'h1);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned op = $urandom_range(0, 9);
            logic [7:0]  d  = ($urandom_range(0, 3) == 0) ? 8'h3F : 8'($urandom);
            logic [13:0] fa = 14'($urandom);
            if ($urandom_range(0, 19) == 0) ren = ~ren;
            step(op == 1 || op == 2, op == 3, op == 4, op == 5, d,
                 1'($urandom), ren, 1'($urandom), fa);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule